// File: doc/BRIEF.md
# Hamming ECC Sector Corrector

The block checks one 512-byte sector against a 3-byte Hamming code and repairs a single flipped data bit in place. A job starts with a one-cycle pulse on `start` that carries two codes: the one kept in the spare area and the one just computed over the data read back. The block spreads each 24-bit code over a 32-bit word and XORs the two words to form a syndrome. It registers the syndrome's population count and then sorts the job into one of four outcomes.

When a data bit can be repaired, the block reads the affected byte from an attached sector buffer. It writes the byte back with the one bit inverted. The buffer is a synchronous-read RAM with one cycle of read latency. A one-cycle `done` pulse ends every job. The outcome and the repair location stay on the outputs until the next job is classified.

Top module: `hamming_sector_fix`

## Requirements
- R1: Each 24-bit code is given as byte0 in [7:0], byte1 in [15:8] and byte2 in [23:16]. It is packed into 32 bits as follows: byte0 goes to bits 7:0 and byte1 to bits 23:16. The high nibble of byte2 goes to bits 27:24 and its low nibble to bits 11:8. All other bits are zero. The syndrome is the XOR of the two packed words.
- R2: A syndrome with exactly 12 ones gives status 1 (corrected). `fix_byte` is syndrome bits 27:19 and `fix_bit` is syndrome bits 18:16.
- R3: After a status 1 outcome, the buffer sees exactly one write, at address `fix_byte`. The write holds the byte previously stored there with only bit `fix_bit` inverted.
- R4: A syndrome with exactly one set bit gives status 2 (code field damaged). There is no buffer write.
- R5: A packed stored code of 0x0FFF0FFF with a computed code of zero is an erased page. It gives status 0 (clean) with no buffer write. Every other combination follows R2, R4, R6 and R7.
- R6: A zero syndrome gives status 0 with no buffer write.
- R7: Any other nonzero syndrome gives status 3 (uncorrectable), with no buffer write.
- R8: `done` is high for exactly one cycle per job. For outcomes without a repair, it is high in the third cycle after the `start` cycle. For repairs, it is high in the fifth cycle after the `start` cycle.
- R9: After reset, `status` is 0 and `done` is low. `status`, `fix_byte` and `fix_bit` change only when a job is classified.
- R10: A `start` pulse while a job is in flight is ignored, along with the codes it carries. A `start` in the same cycle as `done` begins a new job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle job request |
| stored_ecc | input | 24 | Code read from the spare area |
| calc_ecc | input | 24 | Code computed over the data read |
| done | output | 1 | One-cycle job completion pulse |
| status | output | 2 | 0 clean, 1 corrected, 2 code field damaged, 3 uncorrectable |
| fix_byte | output | 9 | Byte address of the repaired bit |
| fix_bit | output | 3 | Bit index of the repaired bit |
| buf_addr | output | 9 | Sector buffer address |
| buf_rd_data | input | 8 | Buffer read data, one cycle after the address |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wr_data | output | 8 | Buffer write data |

## Verification
The completion pulse of one job and the acceptance of the next job's `start` can fall in the same cycle. So can a stray `start` and a job that is still running. The bench raises every new request in the cycle where `done` is seen, so each job in the sweeps begins on that shared cycle. Each job is judged by its own outcome, repair location and latency. One repair job also carries a second `start` with erased-page codes two cycles in. That job must report its original repair with unchanged latency, and no further `done` may follow.

// File: rtl/hsf_pkg.sv
package hsf_pkg;
  localparam int CODE_W = 24;
  localparam int SYN_W  = 32;
  localparam int POP_W  = $clog2(SYN_W + 1);
  localparam int FIX_ONES = 12;
  localparam logic [SYN_W-1:0] ERASED_PACK = 32'h0FFF_0FFF;

  typedef enum logic [1:0] {
    ST_CLEAN  = 2'd0,
    ST_FIXED  = 2'd1,
    ST_ECCERR = 2'd2,
    ST_UNCORR = 2'd3
  } hsf_status_e;

  // spread a 24-bit code over 32 bits, splitting the top byte in nibbles
  function automatic logic [SYN_W-1:0] pack_code(input logic [CODE_W-1:0] c);
    pack_code = {4'h0, c[23:20], c[15:8], 4'h0, c[19:16], c[7:0]};
  endfunction

  function automatic logic [POP_W-1:0] ones(input logic [SYN_W-1:0] v);
    logic [POP_W-1:0] n;
    n = '0;
    for (int i = 0; i < SYN_W; i++) n = n + POP_W'(v[i]);
    return n;
  endfunction

  function automatic hsf_status_e sort_outcome(input logic [POP_W-1:0] n,
                                               input logic erased);
    if (n == '0)                    return ST_CLEAN;
    else if (n == POP_W'(FIX_ONES)) return ST_FIXED;
    else if (n == POP_W'(1))        return ST_ECCERR;
    else if (erased)                return ST_CLEAN;
    else                            return ST_UNCORR;
  endfunction
endpackage

// File: rtl/hsf_syndrome.sv
module hsf_syndrome
  import hsf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] stored,
  input  logic [CODE_W-1:0] calc,
  output logic [SYN_W-1:0]  syn_q,
  output logic              erased_q
);
  logic [SYN_W-1:0] sp, cp;
  assign sp = pack_code(stored);
  assign cp = pack_code(calc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syn_q    <= '0;
      erased_q <= 1'b0;
    end else if (load) begin
      syn_q    <= sp ^ cp;
      erased_q <= (sp == ERASED_PACK) && (cp == '0);
    end
  end
endmodule

// File: rtl/hsf_popcnt.sv
module hsf_popcnt
  import hsf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SYN_W-1:0] syn,
  output logic [POP_W-1:0] pop_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  pop_q <= '0;
    else if (en) pop_q <= ones(syn);
  end
endmodule

// File: rtl/hsf_classify.sv
module hsf_classify
  import hsf_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic [POP_W-1:0]  pop,
  input  logic              erased,
  input  logic [SYN_W-1:0]  syn,
  output hsf_status_e       outcome,
  output logic [ADDR_W-1:0] byte_idx,
  output logic [2:0]        bit_idx
);
  localparam int HALF = SYN_W / 2;

  assign outcome  = sort_outcome(pop, erased);
  assign bit_idx  = syn[HALF +: 3];
  assign byte_idx = syn[HALF + 3 +: ADDR_W];
endmodule

// File: rtl/hamming_sector_fix.sv
module hamming_sector_fix
  import hsf_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  localparam int ADDR_W = $clog2(SECTOR_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [23:0]       stored_ecc,
  input  logic [23:0]       calc_ecc,
  output logic              done,
  output logic [1:0]        status,
  output logic [ADDR_W-1:0] fix_byte,
  output logic [2:0]        fix_bit,
  output logic [ADDR_W-1:0] buf_addr,
  input  logic [7:0]        buf_rd_data,
  output logic              buf_wr_en,
  output logic [7:0]        buf_wr_data
);
  typedef enum logic [2:0] {S_IDLE, S_POP, S_CLASS, S_READ, S_WRITE} fsm_e;
  fsm_e state;

  logic              accept, class_fire, wr_fire;
  logic [SYN_W-1:0]  syn_q;
  logic              erased_q;
  logic [POP_W-1:0]  pop_q;
  hsf_status_e       cls_outcome, status_q;
  logic [ADDR_W-1:0] cls_byte, fix_byte_q;
  logic [2:0]        cls_bit, fix_bit_q;
  logic              done_q;

  assign accept     = (state == S_IDLE) && start;
  assign class_fire = (state == S_CLASS);
  assign wr_fire    = (state == S_WRITE);

  hsf_syndrome u_syn (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .stored(stored_ecc), .calc(calc_ecc),
    .syn_q(syn_q), .erased_q(erased_q)
  );

  hsf_popcnt u_pop (
    .clk(clk), .rst_n(rst_n), .en(state == S_POP),
    .syn(syn_q), .pop_q(pop_q)
  );

  hsf_classify #(.ADDR_W(ADDR_W)) u_cls (
    .pop(pop_q), .erased(erased_q), .syn(syn_q),
    .outcome(cls_outcome), .byte_idx(cls_byte), .bit_idx(cls_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
    end else begin
      unique case (state)
        S_IDLE:  if (start) state <= S_POP;
        S_POP:   state <= S_CLASS;
        S_CLASS: state <= (cls_outcome == ST_FIXED) ? S_READ : S_IDLE;
        S_READ:  state <= S_WRITE;
        S_WRITE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q   <= ST_CLEAN;
      fix_byte_q <= '0;
      fix_bit_q  <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= (class_fire && cls_outcome != ST_FIXED) || wr_fire;
      if (class_fire) begin
        status_q   <= cls_outcome;
        fix_byte_q <= cls_byte;
        fix_bit_q  <= cls_bit;
      end
    end
  end

  assign done        = done_q;
  assign status      = status_q;
  assign fix_byte    = fix_byte_q;
  assign fix_bit     = fix_bit_q;
  assign buf_addr    = fix_byte_q;
  assign buf_wr_en   = wr_fire;
  assign buf_wr_data = buf_rd_data ^ (8'h01 << fix_bit_q);
endmodule

// File: rtl/hsf_chk.sv
module hsf_chk
  import hsf_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic [1:0]       status,
  input logic             buf_wr_en,
  input logic [7:0]       buf_wr_data,
  input logic [7:0]       buf_rd_data,
  input logic             class_fire,
  input logic [POP_W-1:0] pop_q
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !class_fire |=> $stable(status));

  // R3
  wr_single_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |-> ($countones(buf_wr_data ^ buf_rd_data) == 1));

  // R3
  wr_only_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |-> (status == 2'd1));

  // R4
  ecc_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (class_fire && pop_q == POP_W'(1)) |=> (status == 2'd2));

  // R2
  twelve_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (class_fire && pop_q == POP_W'(FIX_ONES)) |=> (status == 2'd1));
endmodule

bind hamming_sector_fix hsf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .status(status),
  .buf_wr_en(buf_wr_en), .buf_wr_data(buf_wr_data),
  .buf_rd_data(buf_rd_data), .class_fire(class_fire), .pop_q(pop_q)
);

// File: tb/hamming_sector_fix_tb.sv
module hamming_sector_fix_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [23:0] stored_ecc = '0, calc_ecc = '0;
  logic done, buf_wr_en;
  logic [1:0] status;
  logic [8:0] fix_byte, buf_addr;
  logic [2:0] fix_bit;
  logic [7:0] buf_rd_data, buf_wr_data;

  int n_chk = 0, n_fail = 0, wr_cnt = 0;
  logic [7:0] mem [512];
  logic [7:0] gold [512];
  logic [23:0] lcg = 24'h5A3C91;

  always #2 clk = ~clk;

  hamming_sector_fix u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stored_ecc(stored_ecc),
    .calc_ecc(calc_ecc), .done(done), .status(status), .fix_byte(fix_byte),
    .fix_bit(fix_bit), .buf_addr(buf_addr), .buf_rd_data(buf_rd_data),
    .buf_wr_en(buf_wr_en), .buf_wr_data(buf_wr_data)
  );

  always @(posedge clk) begin
    buf_rd_data <= mem[buf_addr];
    if (buf_wr_en) begin
      mem[buf_addr] <= buf_wr_data;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int packw(input logic [23:0] c);
    int b0, b1, b2;
    b0 = c[7:0]; b1 = c[15:8]; b2 = c[23:16];
    return b0 | (b1 << 16) | ((b2 & 'hF0) << 20) | ((b2 & 'h0F) << 8);
  endfunction

  function automatic logic [23:0] unpackw(input int p);
    logic [7:0] b2;
    b2 = 8'(((p >> 20) & 'hF0) | ((p >> 8) & 'h0F));
    return {b2, 8'(p >> 16), 8'(p)};
  endfunction

  function automatic int legal_pos(input int i);
    return (i < 12) ? i : i + 4;
  endfunction

  function automatic logic [23:0] next_code();
    lcg = lcg * 24'd1103515 + 24'd12345;
    return lcg;
  endfunction

  // called at a negedge; returns at the negedge where done is seen
  task automatic run_job(input string req, input logic [23:0] s,
                         input logic [23:0] c, input int exp_st,
                         input int exp_byte, input int exp_bit, input bit poke);
    int cyc, w0;
    w0 = wr_cnt;
    stored_ecc = s; calc_ecc = c; start = 1'b1;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (poke && cyc == 2) begin
        stored_ecc = 24'hFFFFFF; calc_ecc = 24'h0; start = 1'b1;
      end
    end while (!done && cyc < 20);
    chk({req, " status"}, status, exp_st);
    chk("R8 latency", cyc, (exp_st == 1) ? 5 : 3);
    if (exp_st == 1) begin
      chk({req, " fix_byte"}, fix_byte, exp_byte);
      chk({req, " fix_bit"}, fix_bit, exp_bit);
      chk("R3 write count", wr_cnt - w0, 1);
      gold[exp_byte] = gold[exp_byte] ^ (8'h01 << exp_bit);
      chk("R3 repaired byte", mem[exp_byte], gold[exp_byte]);
    end else begin
      chk({req, " no write"}, wr_cnt - w0, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    logic [23:0] s;
    int x, fb, fbit, st;
    for (int i = 0; i < 512; i++) begin
      mem[i] = 8'((i * 7 + 3) ^ (i >> 4));
      gold[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset status", status, 0);
    chk("R9 reset done", done, 0);
    chk("R9 reset no write", buf_wr_en, 0);

    // R6: zero syndrome
    for (int k = 0; k < 8; k++) begin
      s = next_code();
      run_job("R6", s, s, 0, 0, 0, 1'b0);
    end

    // R2/R3/R1: every single-bit data error location
    for (int a = 0; a < 4096; a++) begin
      s = next_code();
      x = (a << 16) | (~a & 'hFFF);
      run_job("R2", s, unpackw(packw(s) ^ x), 1, a >> 3, a & 7, 1'b0);
    end

    // R4: single flip in every used position of the code
    for (int i = 0; i < 24; i++) begin
      s = next_code();
      run_job("R4", s, unpackw(packw(s) ^ (1 << legal_pos(i))), 2, 0, 0, 1'b0);
    end

    // R7: several weights other than 0, 1, 12
    for (int k = 2; k <= 24; k++) begin
      if (k == 12) continue;
      x = 0;
      for (int j = 0; j < k; j++) x = x | (1 << legal_pos((j + k) % 24));
      s = next_code();
      run_job("R7", s, unpackw(packw(s) ^ x), 3, 0, 0, 1'b0);
    end

    // R5: erased page, and two near misses
    run_job("R5", 24'hFFFFFF, 24'h000000, 0, 0, 0, 1'b0);
    run_job("R5 near miss calc", 24'hFFFFFF, 24'h000001, 3, 0, 0, 1'b0);
    run_job("R5 near miss stored", 24'hFFFFFE, 24'h000000, 3, 0, 0, 1'b0);

    // R10: stray start with erased codes during a repair job
    s = next_code();
    x = (1234 << 16) | (~1234 & 'hFFF);
    run_job("R10", s, unpackw(packw(s) ^ x), 1, 1234 >> 3, 1234 & 7, 1'b1);
    st = status; fb = fix_byte; fbit = fix_bit;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R10 no extra done", done, 0);
      chk("R9 status held", status, st);
      chk("R9 fix_byte held", fix_byte, fb);
      chk("R9 fix_bit held", fix_bit, fbit);
    end
    chk("R8 done single cycle", done, 0);

    // R1: full buffer matches the expected image
    for (int i = 0; i < 512; i++) chk("R1 buffer image", mem[i], gold[i]);

    summary();
    $finish;
  end
endmodule